// File: doc/BRIEF.md
# Instruction Fetch and Execute Sequencer

This block steps a 16-bit word processor through its instructions. For each instruction it reads the word at the program counter through a single-port memory with one cycle of read latency, and then advances the counter. It then offers the operand fields to an external operand resolver, first operand a and then operand b. When the resolver asks for an extension word, the sequencer fetches that word from the program stream. After both operands are resolved, the sequencer either starts the arithmetic unit or runs one of the extended operations itself: no-operation, subroutine call and stop. If a skip is pending, it throws the instruction away instead.

The sequencer owns the program counter, the stack pointer, the overflow register, the skip flag and the running flag. A skipped instruction still consumes its extension words. Any stack pointer movement caused by its operands is undone, and the pending skip then clears. Each finished instruction produces a one-cycle completion pulse together with the cycle cost counted for that instruction.

Instruction format: bits [3:0] hold the opcode, bits [9:4] hold operand field a, and bits [15:10] hold operand field b. Opcode 0 selects an extended operation. For extended operations, field a holds the extended operation number and only field b is resolved.

Top module: `insn_sequencer`

## Requirements
- R1: Every instruction starts with a memory read at PC. PC then increases by one, and the cycle count restarts at 0.
- R2: When the resolver asserts opr_needs_word for the presented field, the sequencer reads memory at PC. It presents that word on opr_word, increases PC by one and adds 1 to the cycle count.
- R3: An instruction that arrives while the skip flag is set still consumes its extension words. SP returns to the value it had at that instruction's fetch. No alu_go and no memory write occur, O keeps its value and the cycle count holds only the extension-word cost.
- R4: When alu_go coincides with alu_fail, the skip flag is set. The flag applies only to the next instruction and is clear once that instruction completes.
- R5: Extended operation 1 (call) lowers SP by one and writes the PC value (already past any extension words) to memory at the new SP. It then loads PC with the b operand value and adds 2 cycles.
- R6: Extended operation 0 adds 1 cycle and changes no state. Extended operation numbers 3 and above add nothing and change no state.
- R7: Extended operation 2 clears the running flag. After that, no memory read or write ever occurs and PC stays fixed.
- R8: After reset, PC, SP and O are 0, the skip flag is 0, the running flag is 1 and insn_done is 0.
- R9: insn_done is a pulse exactly one cycle wide. While it is high, insn_cycles shows the instruction's total cost, and PC, SP, O, skip and running show the instruction's final state.
- R10: For a non-zero opcode that is not skipped, alu_go is asserted for one cycle with alu_op, alu_a and alu_b. The cycle count gains alu_cycles, and O loads alu_o when alu_o_we is high.
- R11: For a non-zero opcode, field a is resolved before field b. Resolving a field whose opr_sp_step is 01 raises SP by one after use, and a step of 10 lowers SP by one. SP moves modulo 2^16, so lowering SP from 0 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Memory word address |
| mem_rd | output | 1 | Memory read request; data arrives one cycle later |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| opr_field | output | 6 | Operand field being resolved |
| opr_word | output | 16 | Extension word fetched for the current field, or 0 |
| opr_needs_word | input | 1 | Resolver needs an extension word for opr_field |
| opr_value | input | 16 | Resolved operand value |
| opr_sp_step | input | 2 | Stack effect of the field: 00 none, 01 raise, 10 lower |
| alu_go | output | 1 | Start of an arithmetic operation |
| alu_op | output | 4 | Opcode for the arithmetic unit |
| alu_a | output | 16 | Operand a value |
| alu_b | output | 16 | Operand b value |
| alu_cycles | input | 2 | Cost of the operation, including the penalty for a failed test |
| alu_fail | input | 1 | Conditional test failed |
| alu_o_we | input | 1 | Load O with alu_o |
| alu_o | input | 16 | New overflow value |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| o_reg | output | 16 | Overflow register |
| skip | output | 1 | Skip pending for the next instruction |
| running | output | 1 | Running flag |
| insn_done | output | 1 | Instruction completion pulse |
| insn_cycles | output | 4 | Cycle cost of the completed instruction |

## Verification
The assertions assume a memory that answers every read on the cycle after mem_rd. They also assume that the resolver's and arithmetic unit's inputs are stable combinational functions of the values the sequencer presents. The assertions check stack pointer movement after a call write, the absence of alu_go while a skip is pending, silence on the memory port once stopped, and the pulse width of insn_done. The bench meets these assumptions by modelling the memory, resolver and arithmetic unit behaviourally. Its program uses only the extension-word, push, pop and literal fields that its resolver model defines, and keeps the stack (addresses wrapping down from 0xFFFF) apart from the code.

// File: rtl/sq_pkg.sv
// Shared encodings for the instruction sequencer.
// Assumes the fixed instruction layout: opcode [3:0], field a [9:4], field b [15:10].
package sq_pkg;
    localparam int OPC_W = 4;
    localparam int FLD_W = 6;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DEC,
        ST_OPND,
        ST_XRD,
        ST_XCAP,
        ST_EXEC,
        ST_DONE,
        ST_HALT
    } sq_state_e;

    localparam logic [1:0] SPS_UP   = 2'b01;
    localparam logic [1:0] SPS_DOWN = 2'b10;

    localparam logic [FLD_W-1:0] XOP_NOP  = 6'd0;
    localparam logic [FLD_W-1:0] XOP_CALL = 6'd1;
    localparam logic [FLD_W-1:0] XOP_STOP = 6'd2;
endpackage

// File: rtl/sq_cyc.sv
// Per-instruction cycle accumulator.
// Assumes clr and en are never both set in one cycle; clr has priority.
module sq_cyc #(
    parameter int CYC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CYC_W-1:0] add,
    output logic [CYC_W-1:0] cnt
);
    // Restart the count at instruction start, accumulate costs after that.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= cnt + add;
    end
endmodule

// File: rtl/sq_arch.sv
// Architectural state: PC, SP, saved SP, O, skip and running flags.
// Assumes the controller asserts at most one SP-changing strobe per cycle.
module sq_arch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pc_inc,
    input  logic         pc_load,
    input  logic [W-1:0] pc_new,
    input  logic         sp_save,
    input  logic         sp_apply,
    input  logic [1:0]   sp_step,
    input  logic         sp_restore,
    input  logic         sp_dec,
    input  logic         o_load,
    input  logic [W-1:0] o_new,
    input  logic         skip_set,
    input  logic         skip_clr,
    input  logic         run_clr,
    output logic [W-1:0] pc_q,
    output logic [W-1:0] sp_q,
    output logic [W-1:0] o_q,
    output logic         skip_q,
    output logic         run_q
);
    import sq_pkg::*;

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] sp_saved_q;

    // Program counter: a jump load wins over a sequential increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc_q <= '0;
        else if (pc_load) pc_q <= pc_new;
        else if (pc_inc)  pc_q <= pc_q + ONE;
    end

    // Snapshot of SP taken when an instruction is fetched.
    always_ff @(posedge clk) begin
        if (!rst_n)       sp_saved_q <= '0;
        else if (sp_save) sp_saved_q <= sp_q;
    end

    // Stack pointer: rollback, call push, or operand stack effect.
    always_ff @(posedge clk) begin
        if (!rst_n)              sp_q <= '0;
        else if (sp_restore)     sp_q <= sp_saved_q;
        else if (sp_dec)         sp_q <= sp_q - ONE;
        else if (sp_apply) begin
            if (sp_step == SPS_UP)        sp_q <= sp_q + ONE;
            else if (sp_step == SPS_DOWN) sp_q <= sp_q - ONE;
        end
    end

    // Overflow register loaded by the arithmetic unit.
    always_ff @(posedge clk) begin
        if (!rst_n)      o_q <= '0;
        else if (o_load) o_q <= o_new;
    end

    // Skip flag: set by a failed test, cleared when consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)        skip_q <= 1'b0;
        else if (skip_clr) skip_q <= 1'b0;
        else if (skip_set) skip_q <= 1'b1;
    end

    // Running flag: cleared once by the stop operation.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= 1'b1;
        else if (run_clr) run_q <= 1'b0;
    end

    AST_SKIP_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        skip_clr |=> !skip_q); // R4
endmodule

// File: rtl/sq_fsm.sv
// Fetch/decode/resolve/execute controller with the memory port mux.
// Assumes a memory with one cycle read latency and a combinational resolver
// and arithmetic unit answering in the cycle their request is presented.
module sq_fsm #(
    parameter int W     = 16,
    parameter int CYC_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [W-1:0]             mem_rdata,
    input  logic                     opr_needs_word,
    input  logic [W-1:0]             opr_value,
    input  logic [1:0]               alu_cycles,
    input  logic                     alu_fail,
    input  logic                     alu_o_we,
    input  logic [W-1:0]             pc_q,
    input  logic [W-1:0]             sp_q,
    input  logic                     skip_q,
    input  logic                     run_q,
    output logic [W-1:0]             mem_addr,
    output logic                     mem_rd,
    output logic                     mem_wr,
    output logic [W-1:0]             mem_wdata,
    output logic [sq_pkg::FLD_W-1:0] opr_field,
    output logic [W-1:0]             opr_word,
    output logic                     alu_go,
    output logic [sq_pkg::OPC_W-1:0] alu_op,
    output logic [W-1:0]             alu_a,
    output logic [W-1:0]             alu_b,
    output logic                     pc_inc,
    output logic                     pc_load,
    output logic [W-1:0]             pc_new,
    output logic                     sp_save,
    output logic                     sp_apply,
    output logic                     sp_restore,
    output logic                     sp_dec,
    output logic                     o_load,
    output logic                     skip_set,
    output logic                     skip_clr,
    output logic                     run_clr,
    output logic                     cyc_clr,
    output logic                     cyc_en,
    output logic [CYC_W-1:0]         cyc_add,
    output logic                     done
);
    import sq_pkg::*;

    localparam int A_LSB = OPC_W;
    localparam int B_LSB = OPC_W + FLD_W;
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    sq_state_e        state_q, state_d;
    logic [W-1:0]     ir_q, xword_q, a_val_q, b_val_q;
    logic             got_q, sel_a_q;
    logic [OPC_W-1:0] opc;
    logic [FLD_W-1:0] fld_a, fld_b;
    logic             is_basic, resolve, exec_live, do_call;

    assign opc      = ir_q[OPC_W-1:0];
    assign fld_a    = ir_q[A_LSB+FLD_W-1:A_LSB];
    assign fld_b    = ir_q[B_LSB+FLD_W-1:B_LSB];
    assign is_basic = (opc != '0);

    assign opr_field = sel_a_q ? fld_a : fld_b;
    assign opr_word  = got_q ? xword_q : '0;
    assign resolve   = (state_q == ST_OPND) && !(opr_needs_word && !got_q);
    assign exec_live = (state_q == ST_EXEC) && !skip_q;
    assign do_call   = exec_live && !is_basic && (fld_a == XOP_CALL);

    assign alu_go = exec_live && is_basic;
    assign alu_op = opc;
    assign alu_a  = a_val_q;
    assign alu_b  = b_val_q;

    // Memory port: reads for fetch and extension words, write for call.
    always_comb begin
        mem_rd    = (state_q == ST_FETCH) || (state_q == ST_XRD);
        mem_wr    = do_call;
        mem_addr  = do_call ? (sp_q - ONE) : pc_q;
        mem_wdata = pc_q;
    end

    // Strobes towards the register and cycle-count blocks.
    always_comb begin
        pc_inc     = (state_q == ST_DEC) || (state_q == ST_XCAP);
        pc_load    = do_call;
        pc_new     = b_val_q;
        sp_save    = (state_q == ST_FETCH);
        sp_apply   = resolve;
        sp_restore = (state_q == ST_EXEC) && skip_q;
        sp_dec     = do_call;
        o_load     = alu_go && alu_o_we;
        skip_set   = alu_go && alu_fail;
        skip_clr   = (state_q == ST_EXEC) && skip_q;
        run_clr    = exec_live && !is_basic && (fld_a == XOP_STOP);
        cyc_clr    = (state_q == ST_FETCH);
        cyc_en     = 1'b0;
        cyc_add    = '0;
        done       = (state_q == ST_DONE);
        if (state_q == ST_XCAP) begin
            cyc_en  = 1'b1;
            cyc_add = CYC_W'(1);
        end else if (alu_go) begin
            cyc_en  = 1'b1;
            cyc_add = CYC_W'(alu_cycles);
        end else if (do_call) begin
            cyc_en  = 1'b1;
            cyc_add = CYC_W'(2);
        end else if (exec_live && !is_basic && (fld_a == XOP_NOP)) begin
            cyc_en  = 1'b1;
            cyc_add = CYC_W'(1);
        end
    end

    // Next-state selection for the instruction sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_FETCH: state_d = ST_DEC;
            ST_DEC:   state_d = ST_OPND;
            ST_OPND: begin
                if (opr_needs_word && !got_q) state_d = ST_XRD;
                else if (!sel_a_q)            state_d = ST_EXEC;
            end
            ST_XRD:   state_d = ST_XCAP;
            ST_XCAP:  state_d = ST_OPND;
            ST_EXEC:  state_d = ST_DONE;
            ST_DONE:  state_d = run_q ? ST_FETCH : ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    // Instruction, extension word and operand value capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q    <= '0;
            xword_q <= '0;
            a_val_q <= '0;
            b_val_q <= '0;
            got_q   <= 1'b0;
            sel_a_q <= 1'b0;
        end else begin
            case (state_q)
                ST_DEC: begin
                    ir_q    <= mem_rdata;
                    sel_a_q <= (mem_rdata[OPC_W-1:0] != '0);
                    got_q   <= 1'b0;
                end
                ST_XCAP: begin
                    xword_q <= mem_rdata;
                    got_q   <= 1'b1;
                end
                ST_OPND: begin
                    if (resolve) begin
                        got_q <= 1'b0;
                        if (sel_a_q) begin
                            a_val_q <= opr_value;
                            sel_a_q <= 1'b0;
                        end else begin
                            b_val_q <= opr_value;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_ONE_PORT_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R5
endmodule

// File: rtl/insn_sequencer.sv
// Top of the fetch/execute sequencer: controller, architectural registers
// and cycle accumulator. Assumes the surrounding resolver, arithmetic unit
// and single-port memory behave as described in the brief.
module insn_sequencer #(
    parameter int W     = 16,
    parameter int CYC_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic [W-1:0]             mem_addr,
    output logic                     mem_rd,
    output logic                     mem_wr,
    output logic [W-1:0]             mem_wdata,
    input  logic [W-1:0]             mem_rdata,
    output logic [sq_pkg::FLD_W-1:0] opr_field,
    output logic [W-1:0]             opr_word,
    input  logic                     opr_needs_word,
    input  logic [W-1:0]             opr_value,
    input  logic [1:0]               opr_sp_step,
    output logic                     alu_go,
    output logic [sq_pkg::OPC_W-1:0] alu_op,
    output logic [W-1:0]             alu_a,
    output logic [W-1:0]             alu_b,
    input  logic [1:0]               alu_cycles,
    input  logic                     alu_fail,
    input  logic                     alu_o_we,
    input  logic [W-1:0]             alu_o,
    output logic [W-1:0]             pc,
    output logic [W-1:0]             sp,
    output logic [W-1:0]             o_reg,
    output logic                     skip,
    output logic                     running,
    output logic                     insn_done,
    output logic [CYC_W-1:0]         insn_cycles
);
    logic         pc_inc, pc_load, sp_save, sp_apply, sp_restore, sp_dec;
    logic         o_load, skip_set, skip_clr, run_clr, cyc_clr, cyc_en;
    logic [W-1:0] pc_new;
    logic [CYC_W-1:0] cyc_add;

    sq_fsm #(.W(W), .CYC_W(CYC_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .mem_rdata(mem_rdata), .opr_needs_word(opr_needs_word),
        .opr_value(opr_value), .alu_cycles(alu_cycles), .alu_fail(alu_fail),
        .alu_o_we(alu_o_we), .pc_q(pc), .sp_q(sp), .skip_q(skip), .run_q(running),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .opr_field(opr_field), .opr_word(opr_word),
        .alu_go(alu_go), .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
        .pc_inc(pc_inc), .pc_load(pc_load), .pc_new(pc_new),
        .sp_save(sp_save), .sp_apply(sp_apply), .sp_restore(sp_restore), .sp_dec(sp_dec),
        .o_load(o_load), .skip_set(skip_set), .skip_clr(skip_clr), .run_clr(run_clr),
        .cyc_clr(cyc_clr), .cyc_en(cyc_en), .cyc_add(cyc_add), .done(insn_done)
    );

    sq_arch #(.W(W)) u_arch (
        .clk(clk), .rst_n(rst_n),
        .pc_inc(pc_inc), .pc_load(pc_load), .pc_new(pc_new),
        .sp_save(sp_save), .sp_apply(sp_apply), .sp_step(opr_sp_step),
        .sp_restore(sp_restore), .sp_dec(sp_dec),
        .o_load(o_load), .o_new(alu_o),
        .skip_set(skip_set), .skip_clr(skip_clr), .run_clr(run_clr),
        .pc_q(pc), .sp_q(sp), .o_q(o_reg), .skip_q(skip), .run_q(running)
    );

    sq_cyc #(.CYC_W(CYC_W)) u_cyc (
        .clk(clk), .rst_n(rst_n),
        .clr(cyc_clr), .en(cyc_en), .add(cyc_add), .cnt(insn_cycles)
    );

    AST_NO_GO_WHEN_SKIPPING: assert property (@(posedge clk) disable iff (!rst_n)
        alu_go |-> !skip); // R3
    AST_CALL_MOVES_SP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (sp == $past(mem_addr))); // R5
    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (!mem_rd && !mem_wr)); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        insn_done |=> !insn_done); // R9
endmodule

// File: tb/insn_sequencer_tb.sv
module insn_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, opr_word, opr_value;
    logic        mem_rd, mem_wr, opr_needs_word, alu_go, alu_fail, alu_o_we;
    logic [5:0]  opr_field;
    logic [1:0]  opr_sp_step, alu_cycles;
    logic [3:0]  alu_op, insn_cycles;
    logic [15:0] alu_a, alu_b, alu_o, pc, sp, o_reg;
    logic        skip, running, insn_done;

    int checks = 0;
    int fails  = 0;
    int go_cnt = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;

    logic [15:0] mem [0:255];

    always #5 clk = ~clk;

    insn_sequencer u_dut (
        .clk(clk), .rst_n(rst_n),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .opr_field(opr_field), .opr_word(opr_word), .opr_needs_word(opr_needs_word),
        .opr_value(opr_value), .opr_sp_step(opr_sp_step),
        .alu_go(alu_go), .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
        .alu_cycles(alu_cycles), .alu_fail(alu_fail), .alu_o_we(alu_o_we), .alu_o(alu_o),
        .pc(pc), .sp(sp), .o_reg(o_reg), .skip(skip), .running(running),
        .insn_done(insn_done), .insn_cycles(insn_cycles)
    );

    // ---- behavioural environment models ----
    function automatic logic f_needs(input logic [5:0] f);
        return (f >= 6'h10 && f <= 6'h17) || f == 6'h1e || f == 6'h1f;
    endfunction
    function automatic logic [15:0] f_val(input logic [5:0] f, input logic [15:0] w);
        if (f_needs(f))     return w;
        if (f >= 6'h20)     return 16'(f - 6'h20);
        if (f >= 6'h18 && f <= 6'h1a) return 16'h2000 | 16'(f);
        return 16'h1000 | 16'(f);
    endfunction
    function automatic logic [1:0] f_step(input logic [5:0] f);
        if (f == 6'h18) return 2'b01;
        if (f == 6'h1a) return 2'b10;
        return 2'b00;
    endfunction
    function automatic logic a_fail(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            4'hC: return a != b;
            4'hD: return a == b;
            4'hE: return !(a > b);
            4'hF: return (a & b) == 16'h0;
            default: return 1'b0;
        endcase
    endfunction
    function automatic logic [1:0] a_cost(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            4'h1, 4'h9, 4'hA, 4'hB: return 2'd1;
            4'h5, 4'h6:             return 2'd3;
            4'hC, 4'hD, 4'hE, 4'hF: return a_fail(op, a, b) ? 2'd3 : 2'd2;
            default:                return 2'd2;
        endcase
    endfunction
    function automatic logic a_owe(input logic [3:0] op);
        return op == 4'h2 || op == 4'h3;
    endfunction
    function automatic logic [15:0] a_oval(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
        if (op == 4'h2) return ({1'b0, a} + {1'b0, b}) > 17'h0FFFF ? 16'd1 : 16'd0;
        return (a < b) ? 16'd1 : 16'd0;
    endfunction

    always_comb begin
        opr_needs_word = f_needs(opr_field);
        opr_value      = f_val(opr_field, opr_word);
        opr_sp_step    = f_step(opr_field);
        alu_cycles     = a_cost(alu_op, alu_a, alu_b);
        alu_fail       = a_fail(alu_op, alu_a, alu_b);
        alu_o_we       = a_owe(alu_op);
        alu_o          = a_oval(alu_op, alu_a, alu_b);
    end

    // Memory with one cycle read latency, plus activity counters.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
        if (rst_n && alu_go) go_cnt <= go_cnt + 1;
        if (rst_n && mem_wr) wr_cnt <= wr_cnt + 1;
        if (rst_n && mem_rd) rd_cnt <= rd_cnt + 1;
    end

    // ---- reference model state ----
    logic [15:0] m_pc, m_sp, m_o, m_push_addr, m_push_val;
    logic        m_skip, m_run, m_call;
    int          m_cyc, m_go, m_wr;

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [5:0] a, input logic [5:0] b);
        return {b, a, op};
    endfunction

    task automatic load_program();
        for (int i = 0; i < 256; i++) mem[i] = 16'h0;
        mem[0]  = enc(4'h1, 6'h00, 6'h25);
        mem[1]  = enc(4'h2, 6'h1f, 6'h1f); mem[2] = 16'hFFFF; mem[3] = 16'h0003;
        mem[4]  = enc(4'hC, 6'h23, 6'h24);
        mem[5]  = enc(4'h2, 6'h1a, 6'h1f); mem[6] = 16'h1234;
        mem[7]  = enc(4'hC, 6'h23, 6'h23);
        mem[8]  = enc(4'h3, 6'h25, 6'h22);
        mem[9]  = enc(4'hD, 6'h22, 6'h22);
        mem[10] = enc(4'h0, 6'h01, 6'h1f); mem[11] = 16'h0040;
        mem[12] = enc(4'h0, 6'h00, 6'h20);
        mem[13] = enc(4'h0, 6'h05, 6'h27);
        mem[14] = enc(4'h1, 6'h1a, 6'h29);
        mem[15] = enc(4'h1, 6'h18, 6'h21);
        mem[16] = enc(4'h0, 6'h01, 6'h1f); mem[17] = 16'h0030;
        mem[24] = enc(4'h4, 6'h23, 6'h24);
        mem[25] = enc(4'h0, 6'h02, 6'h20);
        mem[48] = enc(4'hE, 6'h25, 6'h22);
        mem[49] = enc(4'hF, 6'h24, 6'h22);
        mem[50] = enc(4'h0, 6'h02, 6'h20);
        mem[51] = enc(4'h0, 6'h01, 6'h38);
    endtask

    task automatic m_resolve(input logic [5:0] f, output logic [15:0] v);
        logic [15:0] w = 16'h0;
        if (f_needs(f)) begin
            w = mem[m_pc[7:0]];
            m_pc = m_pc + 16'd1;
            m_cyc++;
        end
        v = f_val(f, w);
        if (f_step(f) == 2'b01) m_sp = m_sp + 16'd1;
        if (f_step(f) == 2'b10) m_sp = m_sp - 16'd1;
    endtask

    task automatic m_step();
        logic [15:0] c, av, bv, s;
        c = mem[m_pc[7:0]];
        m_pc = m_pc + 16'd1;
        m_cyc = 0; m_go = 0; m_wr = 0; m_call = 1'b0;
        s = m_sp;
        av = 16'h0;
        if (c[3:0] != 4'h0) m_resolve(c[9:4], av);
        m_resolve(c[15:10], bv);
        if (m_skip) begin
            m_sp = s;
            m_skip = 1'b0;
        end else if (c[3:0] != 4'h0) begin
            m_go = 1;
            m_cyc += int'(a_cost(c[3:0], av, bv));
            if (a_owe(c[3:0])) m_o = a_oval(c[3:0], av, bv);
            if (a_fail(c[3:0], av, bv)) m_skip = 1'b1;
        end else begin
            case (c[9:4])
                6'h00: m_cyc += 1;
                6'h01: begin
                    m_sp = m_sp - 16'd1;
                    m_push_addr = m_sp;
                    m_push_val = m_pc;
                    m_pc = bv;
                    m_cyc += 2;
                    m_wr = 1;
                    m_call = 1'b1;
                end
                6'h02: m_run = 1'b0;
                default: ;
            endcase
        end
    endtask

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_reset();
        check16("R8 pc", pc, 16'h0);
        check16("R8 sp", sp, 16'h0);
        check16("R8 o_reg", o_reg, 16'h0);
        check16("R8 skip", {15'h0, skip}, 16'h0);
        check16("R8 running", {15'h0, running}, 16'h1);
        check16("R8 insn_done", {15'h0, insn_done}, 16'h0);
    endtask

    task automatic run_program(input int tag_run);
        int go0, wr0, rd0, wait_n;
        m_pc = 16'h0; m_sp = 16'h0; m_o = 16'h0; m_skip = 1'b0; m_run = 1'b1;
        while (m_run) begin
            go0 = go_cnt; wr0 = wr_cnt;
            m_step();
            wait_n = 0;
            do begin
                @(negedge clk);
                wait_n++;
            end while (!insn_done && wait_n < 100);
            check16("R9 done pulse seen", {15'h0, insn_done}, 16'h1);
            check16("R1 R2 R5 pc", pc, m_pc);
            check16("R3 R11 sp", sp, m_sp);
            check16("R10 R11 o_reg", o_reg, m_o);
            check16("R4 skip", {15'h0, skip}, {15'h0, m_skip});
            check16("R7 running", {15'h0, running}, {15'h0, m_run});
            check16("R2 R6 R9 insn_cycles", {12'h0, insn_cycles}, 16'(m_cyc));
            check16("R3 R10 alu_go count", 16'(go_cnt - go0), 16'(m_go));
            check16("R3 R5 mem write count", 16'(wr_cnt - wr0), 16'(m_wr));
            if (m_call) check16("R5 pushed pc", mem[m_push_addr[7:0]], m_push_val);
            @(negedge clk);
            check16("R9 done width", {15'h0, insn_done}, 16'h0);
        end
        rd0 = rd_cnt;
        repeat (40) @(negedge clk);
        check16("R7 no fetch after stop", 16'(rd_cnt - rd0), 16'h0);
        check16("R7 pc frozen", pc, m_pc);
        if (tag_run == 0) check16("R7 stop address", pc, 16'h001A);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        load_program();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        run_program(0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        run_program(1);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule